// File: doc/BRIEF.md
# Speculative Output Allocator with Duplicate Suppression

This block is the central allocator of a switch fabric in which senders do not wait for permission. In every slot (one clock cycle) each input port may present one request made of a destination output and a packet sequence number. The packet travels with the request. If the request wins, the switch path carries the packet. If it loses, the packet is dropped in that slot and the sender retries later. Input selection has already been made at each sender, so the allocator performs only one round-robin pass per output, with a private rotating pointer for each output.

The allocator keeps, for every input/output pair, the sequence number it last granted. A request carrying that number, or an older one, is a copy of a packet that already got through. Such a request is acknowledged, so the sender can release its buffer entry. It never competes for the output and never switches a path on, which saves switch drive energy. Acknowledge and path-enable outputs are registered and appear one cycle after the request.

There is no back-pressure anywhere. Requests are a plain per-slot strobe with no ready signal, and an input that gets no acknowledge must resend on its own.

Top module: `spec_allocator`

## Requirements
- R1: After reset, `ack` and `path_en` are all zero, every output pointer favours input 0, and no pair has a recorded sequence number, so the first request of any pair counts as new.
- R2: In any slot, at most one input is connected to each output, and an input is connected to at most one output.
- R3: An input that requests but neither wins nor is a duplicate receives no acknowledge and no path. An idle input receives neither.
- R4: Among the eligible inputs of an output, the winner is the first one found scanning upward (with wrap) from that output's pointer. The pointer moves to winner+1 (mod ports) only in a slot where that output grants, and it holds otherwise.
- R5: A request is a duplicate when its pair has a recorded number L and (seq − L) mod 2^SEQ_W is zero or has its top bit set. A duplicate is acknowledged, gets no path, and is excluded from arbitration.
- R6: A request whose (seq − L) mod 2^SEQ_W lies in 1 .. 2^(SEQ_W−1)−1 is new, including across wrap (e.g. 15 followed by 0 for SEQ_W=4).
- R7: `ack` and `path_en` are registered. They reflect the request presented in the cycle before, with a latency of one clock.
- R8: A grant records the sequence number only for its own input/output pair. Other pairs are unaffected.
- R9: Bit o*N_PORTS+i of `path_en` connects input i to output o. Destination field i is `req_dst[i*IW +: IW]` and sequence field i is `req_seq[i*SEQ_W +: SEQ_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Request present on input i |
| req_dst | input | N_PORTS*IW | Destination output per input |
| req_seq | input | N_PORTS*SEQ_W | Sequence number per input |
| ack | output | N_PORTS | Registered acknowledge per input |
| path_en | output | N_PORTS*N_PORTS | Registered switch enable, bit o*N_PORTS+i |

## Verification
The embedded properties assume that a destination field always names an existing output and that the sequence numbers a sender uses to one output stay within half the number space of the last granted one. Without that second condition, a very stale copy would read as new. The stimulus keeps both conditions: destinations are drawn from the legal range, and the directed cases place every distance, including the ambiguous half-space point, deliberately. A reference model in the bench keeps its own pointers and per-pair records. It predicts each slot's acknowledge and path vectors one cycle ahead of the design's registered outputs.

// File: rtl/spalloc_pkg.sv
package spalloc_pkg;
  localparam int DEF_PORTS = 4;
  localparam int DEF_SEQ_W = 4;

  // next position on a ring of n entries
  function automatic int ring_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N  = spalloc_pkg::DEF_PORTS,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] ptr;
  logic          found;
  int            win_idx;

  always_comb begin
    gnt     = '0;
    found   = 1'b0;
    win_idx = 0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
        win_idx  = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (found) ptr <= IW'(spalloc_pkg::ring_next(win_idx, N));
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R2
  AST_GNT_AT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    req[ptr] |-> gnt[ptr]); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> $stable(ptr)); // R4
endmodule

// File: rtl/seq_table.sv
module seq_table #(
  parameter int N     = spalloc_pkg::DEF_PORTS,
  parameter int SEQ_W = spalloc_pkg::DEF_SEQ_W,
  localparam int IW   = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req_valid,
  input  logic [N*IW-1:0]    req_dst,
  input  logic [N*SEQ_W-1:0] req_seq,
  input  logic [N-1:0]       won,
  output logic [N-1:0]       dup
);
  logic [SEQ_W-1:0] last_q [N][N];
  logic [N-1:0]     seen_q [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [IW-1:0]    d;
      logic [SEQ_W-1:0] s, diff;
      d      = req_dst[i*IW +: IW];
      s      = req_seq[i*SEQ_W +: SEQ_W];
      diff   = s - last_q[i][d];
      dup[i] = req_valid[i] && seen_q[i][d] && ((diff == '0) || diff[SEQ_W-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        seen_q[i] <= '0;
        for (int j = 0; j < N; j++) last_q[i][j] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (won[i]) begin
          last_q[i][req_dst[i*IW +: IW]] <= req_seq[i*SEQ_W +: SEQ_W];
          seen_q[i][req_dst[i*IW +: IW]] <= 1'b1;
        end
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    AST_SEEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(seen_q[gi]) & ~seen_q[gi]) == '0)); // R8
    AST_WON_NOT_DUP: assert property (@(posedge clk) disable iff (!rst_n)
      won[gi] |-> !dup[gi]); // R5
  end
endmodule

// File: rtl/spec_allocator.sv
module spec_allocator #(
  parameter int N_PORTS = spalloc_pkg::DEF_PORTS,
  parameter int SEQ_W   = spalloc_pkg::DEF_SEQ_W,
  localparam int IW     = $clog2(N_PORTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS-1:0]       req_valid,
  input  logic [N_PORTS*IW-1:0]    req_dst,
  input  logic [N_PORTS*SEQ_W-1:0] req_seq,
  output logic [N_PORTS-1:0]       ack,
  output logic [N_PORTS*N_PORTS-1:0] path_en
);
  logic [N_PORTS-1:0]              dup, won;
  logic [N_PORTS-1:0][N_PORTS-1:0] elig, gnt;
  logic [N_PORTS*N_PORTS-1:0]      path_d;
  logic [N_PORTS-1:0]              in_busy;

  seq_table #(.N(N_PORTS), .SEQ_W(SEQ_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .req_seq(req_seq), .won(won), .dup(dup)
  );

  for (genvar go = 0; go < N_PORTS; go++) begin : g_out
    always_comb begin
      for (int i = 0; i < N_PORTS; i++)
        elig[go][i] = req_valid[i] && !dup[i] && (req_dst[i*IW +: IW] == IW'(go));
    end
    rr_arbiter #(.N(N_PORTS)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(elig[go]), .gnt(gnt[go])
    );
    assign path_d[go*N_PORTS +: N_PORTS] = gnt[go];

    AST_PATH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(path_en[go*N_PORTS +: N_PORTS])); // R2
  end

  always_comb begin
    won     = '0;
    in_busy = '0;
    for (int o = 0; o < N_PORTS; o++) won = won | gnt[o];
    for (int o = 0; o < N_PORTS; o++)
      for (int i = 0; i < N_PORTS; i++)
        in_busy[i] = in_busy[i] | path_en[o*N_PORTS + i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack     <= '0;
      path_en <= '0;
    end else begin
      ack     <= req_valid & (dup | won);
      path_en <= path_d;
    end
  end

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ack[gi] |-> $past(req_valid[gi])); // R7
    AST_PATH_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      in_busy[gi] |-> ack[gi]); // R3
    AST_NO_DUP_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      dup[gi] |=> !in_busy[gi]); // R5
  end
endmodule

// File: tb/spec_allocator_test.sv
`timescale 1ns/1ps
module spec_allocator_test;
  localparam int N  = 4;
  localparam int SW = 4;
  localparam int IW = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     req_valid = '0;
  logic [N*IW-1:0]  req_dst = '0;
  logic [N*SW-1:0]  req_seq = '0;
  logic [N-1:0]     ack;
  logic [N*N-1:0]   path_en;

  spec_allocator #(.N_PORTS(N), .SEQ_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .req_seq(req_seq), .ack(ack), .path_en(path_en)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int          mptr [N];
  logic [SW-1:0] mlast [N][N];
  bit          mseen [N][N];

  logic [N-1:0]   q_ack [$];
  logic [N*N-1:0] q_path [$];
  string          q_tag [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N*IW-1:0] pd(int a, int b, int c, int e);
    return {IW'(e), IW'(c), IW'(b), IW'(a)};
  endfunction
  function automatic logic [N*SW-1:0] ps(int a, int b, int c, int e);
    return {SW'(e), SW'(c), SW'(b), SW'(a)};
  endfunction

  // driver: one slot of requests plus the predicted outcome
  task automatic slot(input logic [N-1:0] v, input logic [N*IW-1:0] df,
                      input logic [N*SW-1:0] sf, input string tag);
    logic [N-1:0]   dupv, wonv;
    logic [N*N-1:0] ep;
    @(negedge clk);
    req_valid = v; req_dst = df; req_seq = sf;
    dupv = '0; wonv = '0; ep = '0;
    for (int i = 0; i < N; i++) begin
      int d;
      logic [SW-1:0] s, diff;
      d = int'(df[i*IW +: IW]);
      s = sf[i*SW +: SW];
      diff = s - mlast[i][d];
      dupv[i] = v[i] && mseen[i][d] && ((diff == '0) || diff[SW-1]);
    end
    for (int o = 0; o < N; o++) begin
      bit got;
      got = 0;
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (mptr[o] + k) % N;
        if (!got && v[idx] && !dupv[idx] && int'(df[idx*IW +: IW]) == o) begin
          got = 1;
          wonv[idx] = 1'b1;
          ep[o*N + idx] = 1'b1;
          mptr[o] = (idx + 1) % N;
          mlast[idx][o] = sf[idx*SW +: SW];
          mseen[idx][o] = 1;
        end
      end
    end
    q_ack.push_back(v & (dupv | wonv));
    q_path.push_back(ep);
    q_tag.push_back(tag);
  endtask

  // monitor: results of a slot appear after the following edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q_ack.size() > 0) begin
        logic [N-1:0]   ea;
        logic [N*N-1:0] ep;
        string          t;
        ea = q_ack.pop_front();
        ep = q_path.pop_front();
        t  = q_tag.pop_front();
        chk(ack == ea, t, "ack", 32'(ack), 32'(ea));
        chk(path_en == ep, t, "path_en", 32'(path_en), 32'(ep));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mptr[i] = 0;
      for (int j = 0; j < N; j++) begin mlast[i][j] = '0; mseen[i][j] = 0; end
    end
    repeat (3) @(posedge clk);
    #1;
    chk(ack == '0, "R1", "reset ack", 32'(ack), 0);
    chk(path_en == '0, "R1", "reset path_en", 32'(path_en), 0);
    @(negedge clk);
    rst_n = 1'b1;

    slot(4'b0000, pd(0,0,0,0), ps(0,0,0,0), "R3 idle");
    slot(4'b0011, pd(2,2,0,0), ps(1,1,0,0), "R1 R4 ptr starts at input0");
    slot(4'b0011, pd(2,2,0,0), ps(2,1,0,0), "R4 pointer moved, R3 loser");
    slot(4'b0011, pd(2,2,0,0), ps(2,1,0,0), "R5 equal seq is duplicate");
    slot(4'b0001, pd(2,0,0,0), ps(0,0,0,0), "R5 older seq is duplicate");
    slot(4'b0001, pd(3,0,0,0), ps(0,0,0,0), "R8 other pair is new");
    slot(4'b1000, pd(0,0,0,0), ps(0,0,0,14), "R6 first of pair");
    slot(4'b1000, pd(0,0,0,0), ps(0,0,0,15), "R6 next seq");
    slot(4'b1000, pd(0,0,0,0), ps(0,0,0,0), "R6 wrap to zero");
    slot(4'b1000, pd(0,0,0,0), ps(0,0,0,8), "R5 half-space distance is duplicate");
    slot(4'b1000, pd(0,0,0,0), ps(0,0,0,7), "R6 distance seven is new");
    for (int k = 0; k < 4; k++)
      slot(4'b1111, pd(1,1,1,1), ps(3+k,3+k,3+k,3+k), "R2 R4 full contention rotation");
    slot(4'b1111, pd(0,1,2,3), ps(9,9,9,9), "R9 R2 distinct outputs");
    slot(4'b1111, pd(0,1,2,3), ps(9,9,9,9), "R5 all duplicates");
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0]    v;
      logic [N*IW-1:0] d;
      logic [N*SW-1:0] s;
      v = N'($urandom);
      d = (N*IW)'($urandom);
      s = (N*SW)'($urandom);
      slot(v, d, s, "R2 R7 random slots");
    end
    slot(4'b0000, pd(0,0,0,0), ps(0,0,0,0), "R3 idle tail");
    repeat (3) @(posedge clk);
    #2;
    chk(q_ack.size() == 0, "R7", "pending results", 32'(q_ack.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule